// File: doc/BRIEF.md
# Symmetric Up/Down PWM Generator

This block produces center-aligned pulse-width modulation for drives and other loads that benefit from symmetric switching. A 16-bit counter climbs from zero to a ceiling value and then falls back to zero, repeating without pause. A counting step happens only in clock cycles where the prescaler `tick` input is high. Each compare channel compares its threshold with the counter and drives one PWM pin. A compare match while climbing moves the pin one way, and a match while falling moves it the other way. The pulse is therefore centered on the bottom of every period.

The ceiling can be one of three fixed widths (8, 9 or 10 bits). It can also come from a period input or from the threshold of channel A. A ceiling taken from an input is never allowed below 3. Each channel has its own 2-bit output mode, which can park the pin low, drive it non-inverted or drive it inverted. The block has no streaming data path. Every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure to observe. Inputs are sampled every clock and take effect at once.

Top module: `pwm_dual_slope`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `count` is 0, `cnt_up` is 1, and every `pwm_out` bit, `top_flag` and `bot_flag` are 0.
- R2: `count` changes only at a clock edge where `tick` is high, and it then changes by exactly one, up or down.
- R3: The counter goes 0,1,...,TOP,TOP-1,...,1,0,1,... with no hold at either end, so a period is 2·TOP ticks. `cnt_up` is 1 while the count is rising, including the cycles it shows TOP. `cnt_up` is 0 while the count is falling, including the cycles it shows 0. If TOP drops below the count while it is rising, the counter turns downward at the next tick.
- R4: `top_flag` is high for exactly the one clock in which `count` first shows TOP after rising. `bot_flag` is high for exactly the one clock in which `count` first shows 0 after falling.
- R5: `top_sel` picks TOP as follows: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives `period_val`, 4 gives channel A's threshold (bits 15:0 of `cmp_val`), and codes 5 to 7 give 0x00FF.
- R6: A TOP taken from `period_val` or from channel A's threshold that is below 3 is raised to 3.
- R7: Channel n has a 2-bit mode field in `out_mode[2n+1:2n]`. The value 00 or 01 holds `pwm_out[n]` low. The value 10 gives the non-inverted waveform and 11 gives the inverted waveform.
- R8: For a threshold C with 0 < C < TOP, the non-inverted level is high when the shown count is below C while rising, or is at most C while falling. The level therefore drops at the match on the way up and rises at the match on the way down. `pwm_out` changes in the same clock as `count`.
- R9: With a threshold of 0, the non-inverted level stays low for the whole period. With a threshold equal to or above TOP, it stays high.
- R10: The inverted waveform (mode 11) is the exact complement of the non-inverted waveform for the same threshold and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler enable; one counting step per high cycle |
| top_sel | input | 3 | Ceiling source select |
| period_val | input | 16 | Ceiling when `top_sel` is 3 |
| cmp_val | input | 32 | Channel thresholds, channel n in bits 16n+15:16n |
| out_mode | input | 4 | Channel output modes, channel n in bits 2n+1:2n |
| pwm_out | output | 2 | PWM pin per channel |
| count | output | 16 | Current counter value |
| cnt_up | output | 1 | High while counting upward |
| top_flag | output | 1 | One-clock pulse on reaching the ceiling |
| bot_flag | output | 1 | One-clock pulse on reaching zero |

## Verification
If the counter direction state is wrong, the error shows on `count` at the next tick: the count overshoots the ceiling, wraps below zero, or turns early, and `cnt_up` disagrees with the trend. If the ceiling is resolved wrongly, the peak of `count` moves and `top_flag` appears at the wrong value, within one half-period. A fault in a channel's match or polarity logic flips `pwm_out` at the first crossing of that threshold, in the clock where `count` reaches it. Flag pulses that stick or are missing show up on the clock after the turn.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_RSV    = 2'b01,
    OUT_NONINV = 2'b10,
    OUT_INV    = 2'b11
  } out_mode_e;

  typedef enum logic [2:0] {
    TOP_FIX8   = 3'd0,
    TOP_FIX9   = 3'd1,
    TOP_FIX10  = 3'd2,
    TOP_PERIOD = 3'd3,
    TOP_CMPA   = 3'd4
  } top_src_e;
endpackage

// File: rtl/pwm_top_resolve.sv
module pwm_top_resolve
  import pwm_dual_pkg::*;
#(
  parameter int W       = 16,
  parameter int MIN_TOP = 3,
  parameter int FIX_A   = 8,
  parameter int FIX_B   = 9,
  parameter int FIX_C   = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   top_sel,
  input  logic [W-1:0] period_val,
  input  logic [W-1:0] cmp_a,
  output logic [W-1:0] top_val
);
  localparam logic [W-1:0] TOP_A = W'((64'd1 << FIX_A) - 64'd1);
  localparam logic [W-1:0] TOP_B = W'((64'd1 << FIX_B) - 64'd1);
  localparam logic [W-1:0] TOP_C = W'((64'd1 << FIX_C) - 64'd1);
  localparam logic [W-1:0] FLOOR = W'(MIN_TOP);

  logic [W-1:0] reg_src;

  always_comb begin
    reg_src = (top_sel == TOP_CMPA) ? cmp_a : period_val;
    if (reg_src < FLOOR) reg_src = FLOOR;
    unique case (top_sel)
      TOP_FIX9:             top_val = TOP_B;
      TOP_FIX10:            top_val = TOP_C;
      TOP_PERIOD, TOP_CMPA: top_val = reg_src;
      default:              top_val = TOP_A;
    endcase
  end

  // R6
  top_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_val >= FLOOR);
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt_q,
  output logic         dir_q,
  output logic [W-1:0] cnt_nx,
  output logic         dir_nx,
  output logic         top_flag,
  output logic         bot_flag
);
  logic top_hit, bot_hit;

  always_comb begin
    cnt_nx  = cnt_q;
    dir_nx  = dir_q;
    top_hit = 1'b0;
    bot_hit = 1'b0;
    if (tick) begin
      if (dir_q) begin
        if (cnt_q >= top_val) begin
          dir_nx = 1'b0;
          cnt_nx = cnt_q - 1'b1;
        end else begin
          cnt_nx  = cnt_q + 1'b1;
          top_hit = (cnt_nx == top_val);
        end
      end else begin
        if (cnt_q == '0) begin
          dir_nx = 1'b1;
          cnt_nx = W'(1);
        end else begin
          cnt_nx  = cnt_q - 1'b1;
          bot_hit = (cnt_nx == '0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_q    <= 1'b1;
      top_flag <= 1'b0;
      bot_flag <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      dir_q    <= dir_nx;
      top_flag <= top_hit;
      bot_flag <= bot_hit;
    end
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  top_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_flag |-> (dir_q && cnt_q == $past(top_val)));
  // R4
  bot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bot_flag |-> (!dir_q && cnt_q == '0));
  // R4
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_flag |=> !top_flag);
  // R3
  no_flag_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_flag && bot_flag));
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_dual_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_nx,
  input  logic         dir_nx,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   mode,
  output logic         pwm_q
);
  logic lvl, pin_nx;
  out_mode_e md;

  always_comb begin
    md = out_mode_e'(mode);
    if (cmp == '0)            lvl = 1'b0;
    else if (cmp >= top_val)  lvl = 1'b1;
    else if (dir_nx)          lvl = (cnt_nx < cmp);
    else                      lvl = (cnt_nx <= cmp);
    unique case (md)
      OUT_NONINV: pin_nx = lvl;
      OUT_INV:    pin_nx = ~lvl;
      default:    pin_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pin_nx;
  end

  // R7
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !pwm_q);
  // R9
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && cmp == '0) |=> !pwm_q);
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_dual_pkg::*;
#(
  parameter int W       = 16,
  parameter int NCH     = 2,
  parameter int MIN_TOP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       top_sel,
  input  logic [W-1:0]     period_val,
  input  logic [NCH*W-1:0] cmp_val,
  input  logic [2*NCH-1:0] out_mode,
  output logic [NCH-1:0]   pwm_out,
  output logic [W-1:0]     count,
  output logic             cnt_up,
  output logic             top_flag,
  output logic             bot_flag
);
  logic [W-1:0] top_val, cnt_nx;
  logic         dir_nx;

  pwm_top_resolve #(.W(W), .MIN_TOP(MIN_TOP)) u_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .top_sel    (top_sel),
    .period_val (period_val),
    .cmp_a      (cmp_val[W-1:0]),
    .top_val    (top_val)
  );

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .top_val  (top_val),
    .cnt_q    (count),
    .dir_q    (cnt_up),
    .cnt_nx   (cnt_nx),
    .dir_nx   (dir_nx),
    .top_flag (top_flag),
    .bot_flag (bot_flag)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_cmp_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nx  (cnt_nx),
      .dir_nx  (dir_nx),
      .top_val (top_val),
      .cmp     (cmp_val[g*W +: W]),
      .mode    (out_mode[2*g +: 2]),
      .pwm_q   (pwm_out[g])
    );
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (count == '0 && cnt_up && pwm_out == '0 && !top_flag && !bot_flag));
endmodule

// File: tb/tb_pwm_dual_slope.sv
module tb_pwm_dual_slope;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [2:0] top_sel = 3'd0;
  logic [W-1:0] period_val = '0;
  logic [2*W-1:0] cmp_val = '0;
  logic [3:0] out_mode = '0;
  logic [1:0] pwm_out;
  logic [W-1:0] count;
  logic cnt_up, top_flag, bot_flag;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwm_dual_slope dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(top_sel),
    .period_val(period_val), .cmp_val(cmp_val), .out_mode(out_mode),
    .pwm_out(pwm_out), .count(count), .cnt_up(cnt_up),
    .top_flag(top_flag), .bot_flag(bot_flag)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic dir, tf, bf, pa, pb;
    string creq, preqa, preqb;
  } exp_t;

  exp_t q[$];
  string creq = "R3", preqa = "R8", preqb = "R10";

  logic [W-1:0] m_cnt = '0;
  logic m_dir = 1'b1;

  function automatic logic [W-1:0] top_of();
    logic [W-1:0] r;
    case (top_sel)
      3'd1: return 16'h01FF;
      3'd2: return 16'h03FF;
      3'd3: r = period_val;
      3'd4: r = cmp_val[W-1:0];
      default: return 16'h00FF;
    endcase
    return (r < 3) ? 16'd3 : r;
  endfunction

  function automatic logic pin(logic [W-1:0] c, logic d, logic [W-1:0] t,
                               logic [W-1:0] cm, logic [1:0] md);
    logic l;
    if (cm == 0) l = 1'b0;
    else if (cm >= t) l = 1'b1;
    else l = d ? (c < cm) : (c <= cm);
    if (md == 2'b10) return l;
    if (md == 2'b11) return !l;
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t);
    exp_t e;
    logic [W-1:0] tp;
    @(negedge clk);
    tick = t;
    tp = top_of();
    e.tf = 1'b0; e.bf = 1'b0;
    if (t) begin
      if (m_dir) begin
        if (m_cnt >= tp) begin m_dir = 1'b0; m_cnt = m_cnt - 1; end
        else begin m_cnt = m_cnt + 1; e.tf = (m_cnt == tp); end
      end else begin
        if (m_cnt == 0) begin m_dir = 1'b1; m_cnt = 1; end
        else begin m_cnt = m_cnt - 1; e.bf = (m_cnt == 0); end
      end
    end
    e.cnt = m_cnt; e.dir = m_dir;
    e.pa = pin(m_cnt, m_dir, tp, cmp_val[W-1:0], out_mode[1:0]);
    e.pb = pin(m_cnt, m_dir, tp, cmp_val[2*W-1:W], out_mode[3:2]);
    e.creq = creq; e.preqa = preqa; e.preqb = preqb;
    q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.creq, "count", int'(count), int'(e.cnt));
      chk(e.creq, "cnt_up", int'(cnt_up), int'(e.dir));
      chk("R4", "top_flag", int'(top_flag), int'(e.tf));
      chk("R4", "bot_flag", int'(bot_flag), int'(e.bf));
      chk(e.preqa, "pwm_a", int'(pwm_out[0]), int'(e.pa));
      chk(e.preqb, "pwm_b", int'(pwm_out[1]), int'(e.pb));
    end
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "cnt_up", int'(cnt_up), 1);
    chk("R1", "pwm", int'(pwm_out), 0);
    chk("R1", "flags", int'({top_flag, bot_flag}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: period 1 clamps to TOP 3; R8/R10 threshold 2
    creq = "R6"; preqa = "R8"; preqb = "R10";
    top_sel = 3'd3; period_val = 16'd1;
    cmp_val = {16'd2, 16'd2}; out_mode = 4'b1110;
    for (int i = 0; i < 40; i++) step(1'b1);

    // R2: sparse ticks; R9 zero threshold and threshold at TOP
    creq = "R2"; preqa = "R9"; preqb = "R9";
    period_val = 16'd6; cmp_val = {16'd6, 16'd0}; out_mode = 4'b1010;
    for (int i = 0; i < 90; i++) step(i % 3 == 0);

    // R5: TOP from channel A threshold; R7 mode 01 parks channel B
    creq = "R5"; preqa = "R9"; preqb = "R7";
    top_sel = 3'd4; cmp_val = {16'd3, 16'd7}; out_mode = 4'b0110;
    for (int i = 0; i < 40; i++) step(1'b1);
    out_mode = 4'b0011;
    preqa = "R10"; preqb = "R7";
    cmp_val = {16'd3, 16'd5};
    for (int i = 0; i < 30; i++) step(1'b1);

    // R3: shrink TOP below count while rising
    creq = "R3"; preqa = "R8"; preqb = "R10";
    top_sel = 3'd3; period_val = 16'd40; cmp_val = {16'd9, 16'd20}; out_mode = 4'b1110;
    for (int i = 0; i < 30; i++) step(1'b1);
    period_val = 16'd10;
    for (int i = 0; i < 60; i++) step(1'b1);

    // R5: fixed widths, including an unused code
    creq = "R5";
    top_sel = 3'd0; cmp_val = {16'd100, 16'd100};
    for (int i = 0; i < 600; i++) step(1'b1);
    top_sel = 3'd1; cmp_val = {16'd300, 16'd300};
    for (int i = 0; i < 1100; i++) step(1'b1);
    top_sel = 3'd2; cmp_val = {16'd1000, 16'd5};
    for (int i = 0; i < 2100; i++) step(1'b1);
    top_sel = 3'd6;
    for (int i = 0; i < 600; i++) step(1'b1);

    @(negedge clk);
    chk("R2", "queue drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule